// File: doc/BRIEF.md
# Key Slot Allocator with Reserved Entries

This block keeps track of which entries of a sixteen-entry hardware key table are taken. A one-hot occupancy vector, where a set bit means the entry is taken or unavailable, is the whole of its state. Three entries (0, 14 and 15) are held busy for good. Requests arrive one at a time over a valid/ready handshake. Each request allocates the lowest free entry, releases an entry, asks whether an identifier names a live entry, submits a key (reusing a live entry when it already has one), or invalidates an entry.

Invalidation first asks a downstream key-table writer to overwrite the entry with an all-zero key at full width. It waits for that writer to report completion and only then releases the entry. Identifier 0 serves both as the allocation-failure result and as the "no key held" identifier, so invalidating it does nothing.

Top module: `key_slot_alloc`

## Requirements
- R1: After reset, entries 0, 14 and 15 are busy and all others are free. `req_ready` is high and `rsp_valid`, `err_pulse` and `wr_valid` are low. Entries 0, 14 and 15 never become free.
- R2: The opcode is carried on `req_op`: 0 allocate, 1 free, 2 query, 3 invalidate, 4 submit. Allocate marks the lowest-numbered free entry busy and returns its index on `rsp_id` with `rsp_fail` low.
- R3: An allocate when no entry is free returns `rsp_id` 0 with `rsp_fail` high. Any response with `rsp_fail` high carries `rsp_id` 0.
- R4: A query sets `rsp_hit` only when `req_id` (5 bits) is at most 15, does not name entry 0, 14 or 15, and names a busy entry.
- R5: Freeing an in-range, non-reserved identifier clears its bit and returns the identifier. A later allocate can return that entry again.
- R6: Freeing entry 0, 14, 15 or an identifier above 15 leaves the table unchanged. So do opcodes 5 to 7, and invalidating an identifier above 15. Each of these gives a response with `rsp_fail` high and a one-cycle `err_pulse`.
- R7: Invalidating identifier 0 issues no write, responds at once with `rsp_fail` low, and changes nothing.
- R8: Invalidating identifiers 1 to 15 raises `wr_valid`, puts the identifier on `wr_slot` and drives `wr_key` to all zeros. These hold with `req_ready` low until `wr_done` is seen. The response then follows, and the entry is freed unless it is reserved.
- R9: A submit whose `req_id` would hit on a query returns that same identifier and allocates nothing. Any other submit behaves as an allocate.
- R10: Every response is registered. `rsp_valid` is high for exactly the one cycle after the request is accepted, or after `wr_done` is seen for an invalidate. A request accepted in the cycle after another sees the table as updated by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | Request opcode |
| req_id | input | 5 | Key identifier for free, query, invalidate and submit |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_id | output | 4 | Resulting entry index, 0 on failure |
| rsp_fail | output | 1 | Request failed or was rejected |
| rsp_hit | output | 1 | Query result |
| err_pulse | output | 1 | One-cycle rejected-request flag |
| wr_valid | output | 1 | Zero-key write request to the key-table writer |
| wr_slot | output | 4 | Entry to overwrite |
| wr_key | output | 256 | Key value to write, always zero |
| wr_done | input | 1 | Key-table writer finished |

## Verification
Two events can share a cycle. In the first, the writer's completion arrives while the next request is already waiting on `req_valid`. The bench holds a query valid through the final waiting cycle. It then checks that the invalidate response comes first, with ready still low, and that the query is taken one cycle later and sees the freed entry. In the second, a request is accepted in the same cycle the previous response is registered. Back-to-back free/query and allocate/query pairs check that the second request observes the table change made by the first.

// File: rtl/kslot_pkg.sv
package kslot_pkg;
    typedef enum logic [2:0] {
        OP_ALLOC  = 3'd0,
        OP_FREE   = 3'd1,
        OP_QUERY  = 3'd2,
        OP_INVAL  = 3'd3,
        OP_SUBMIT = 3'd4
    } kop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } kst_e;
endpackage

// File: rtl/kslot_lowest_free.sv
module kslot_lowest_free #(
    parameter int unsigned SLOTS = 16,
    parameter int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] busy,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // scan from the top so the lowest zero bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = i[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/kslot_member.sv
module kslot_member #(
    parameter int unsigned     SLOTS = 16,
    parameter int unsigned     IDX_W = $clog2(SLOTS),
    parameter int unsigned     ID_W  = IDX_W + 1,
    parameter logic [SLOTS-1:0] RSVD = 16'hC001
) (
    input  logic [SLOTS-1:0] busy,
    input  logic [ID_W-1:0]  id,
    output logic             in_range,
    output logic             releasable,
    output logic             hit
);
    logic [IDX_W-1:0] low;

    always_comb begin
        low        = id[IDX_W-1:0];
        in_range   = (id < ID_W'(SLOTS));
        releasable = in_range && !RSVD[low];
        hit        = releasable && busy[low];
    end
endmodule

// File: rtl/key_slot_alloc.sv
module key_slot_alloc
    import kslot_pkg::*;
#(
    parameter int unsigned      SLOTS = 16,
    parameter logic [SLOTS-1:0] RSVD  = 16'hC001,
    parameter int unsigned      KEY_W = 256,
    localparam int unsigned     IDX_W = $clog2(SLOTS),
    localparam int unsigned     ID_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [ID_W-1:0]  req_id,
    output logic             rsp_valid,
    output logic [IDX_W-1:0] rsp_id,
    output logic             rsp_fail,
    output logic             rsp_hit,
    output logic             err_pulse,
    output logic             wr_valid,
    output logic [IDX_W-1:0] wr_slot,
    output logic [KEY_W-1:0] wr_key,
    input  logic             wr_done
);
    typedef struct packed {
        kst_e             st;
        logic [SLOTS-1:0] busy;
        logic             rsp_v;
        logic [IDX_W-1:0] rsp_id;
        logic             fail;
        logic             hit;
        logic             err;
        logic [IDX_W-1:0] wslot;
        logic             wclr;
    } regs_t;

    regs_t r_q, r_d;

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic             id_in_range, id_releasable, id_hit;
    logic [IDX_W-1:0] id_low;

    kslot_lowest_free #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_pick (
        .busy  (r_q.busy),
        .found (free_found),
        .idx   (free_idx)
    );

    kslot_member #(.SLOTS(SLOTS), .IDX_W(IDX_W), .ID_W(ID_W), .RSVD(RSVD)) u_member (
        .busy       (r_q.busy),
        .id         (req_id),
        .in_range   (id_in_range),
        .releasable (id_releasable),
        .hit        (id_hit)
    );

    assign id_low = req_id[IDX_W-1:0];

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        r_d.err   = 1'b0;
        if (r_q.st == ST_IDLE && req_valid) begin
            r_d.rsp_v  = 1'b1;
            r_d.rsp_id = '0;
            r_d.fail   = 1'b0;
            r_d.hit    = 1'b0;
            case (req_op)
                OP_ALLOC, OP_SUBMIT: begin
                    if (req_op == OP_SUBMIT && id_hit) begin
                        r_d.rsp_id = id_low;
                    end else if (free_found) begin
                        r_d.busy[free_idx] = 1'b1;
                        r_d.rsp_id         = free_idx;
                    end else begin
                        r_d.fail = 1'b1;
                    end
                end
                OP_FREE: begin
                    if (id_releasable) begin
                        r_d.busy[id_low] = 1'b0;
                        r_d.rsp_id       = id_low;
                    end else begin
                        r_d.fail = 1'b1;
                        r_d.err  = 1'b1;
                    end
                end
                OP_QUERY: begin
                    r_d.hit = id_hit;
                end
                OP_INVAL: begin
                    if (!id_in_range) begin
                        r_d.fail = 1'b1;
                        r_d.err  = 1'b1;
                    end else if (id_low != '0) begin
                        r_d.rsp_v = 1'b0;
                        r_d.st    = ST_WAIT;
                        r_d.wslot = id_low;
                        r_d.wclr  = id_releasable;
                    end
                end
                default: begin
                    r_d.fail = 1'b1;
                    r_d.err  = 1'b1;
                end
            endcase
        end else if (r_q.st == ST_WAIT && wr_done) begin
            r_d.st     = ST_IDLE;
            r_d.rsp_v  = 1'b1;
            r_d.rsp_id = r_q.wslot;
            r_d.fail   = 1'b0;
            r_d.hit    = 1'b0;
            if (r_q.wclr) begin
                r_d.busy[r_q.wslot] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.busy  <= RSVD;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign rsp_valid = r_q.rsp_v;
    assign rsp_id    = r_q.rsp_id;
    assign rsp_fail  = r_q.fail;
    assign rsp_hit   = r_q.hit;
    assign err_pulse = r_q.err;
    assign wr_valid  = (r_q.st == ST_WAIT);
    assign wr_slot   = r_q.wslot;
    assign wr_key    = '0;

    // reserved entries stay busy
    assert_reserved_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy & RSVD) == RSVD);

    // the picker returns a free entry with every lower entry busy
    assert_alloc_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        free_found |-> (!r_q.busy[free_idx] &&
            ((r_q.busy | ~(({{(SLOTS-1){1'b0}}, 1'b1} << free_idx) - 1'b1)) == '1)));

    assert_fail_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fail) |-> (rsp_id == '0));

    assert_err_is_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (rsp_valid && rsp_fail));

    assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_done) |=> (wr_valid && $stable(wr_slot) && !rsp_valid));

    assert_rsp_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(wr_valid && wr_done)));
endmodule

// File: tb/key_slot_alloc_test.sv
module key_slot_alloc_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [2:0]   req_op = '0;
    logic [4:0]   req_id = '0;
    logic         rsp_valid;
    logic [3:0]   rsp_id;
    logic         rsp_fail;
    logic         rsp_hit;
    logic         err_pulse;
    logic         wr_valid;
    logic [3:0]   wr_slot;
    logic [255:0] wr_key;
    logic         wr_done = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;
    logic [15:0] mdl = 16'hC001;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_slot_alloc uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_id(req_id), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
        .rsp_fail(rsp_fail), .rsp_hit(rsp_hit), .err_pulse(err_pulse),
        .wr_valid(wr_valid), .wr_slot(wr_slot), .wr_key(wr_key), .wr_done(wr_done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual %0d expected <%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < 16; i++) if (!mdl[i]) return i;
        return -1;
    endfunction

    function automatic bit exp_hit(int id);
        return id < 16 && id != 0 && id != 14 && id != 15 && mdl[id];
    endfunction

    task automatic issue(int op, int id);
        @(negedge clk);
        req_valid = 1'b1; req_op = op[2:0]; req_id = id[4:0];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ready", req_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 wr_valid", wr_valid, 0);
        chk("R1 err", err_pulse, 0);
    endtask

    task automatic t_alloc(string tag);
        int e;
        e = lowest_free();
        issue(0, 0);
        chk({tag, " rsp_valid"}, rsp_valid, 1);
        if (e >= 0) begin
            chk({tag, " id"}, rsp_id, e);
            chk({tag, " fail"}, rsp_fail, 0);
            mdl[e] = 1'b1;
        end else begin
            chk({tag, " R3 id"}, rsp_id, 0);
            chk({tag, " R3 fail"}, rsp_fail, 1);
        end
    endtask

    task automatic t_query(int id);
        issue(2, id);
        chk($sformatf("R4 query %0d", id), rsp_hit, exp_hit(id));
    endtask

    task automatic t_free(int id);
        bit ok;
        ok = id < 16 && id != 0 && id != 14 && id != 15;
        issue(1, id);
        chk($sformatf("R5/R6 free %0d fail", id), rsp_fail, !ok);
        chk($sformatf("R6 free %0d err", id), err_pulse, !ok);
        if (ok) begin
            chk("R5 free id", rsp_id, id);
            mdl[id] = 1'b0;
        end
        @(negedge clk);
        chk("R6 err one cycle", err_pulse, 0);
        chk("R10 rsp one cycle", rsp_valid, 0);
    endtask

    task automatic t_submit(int id);
        int e;
        if (exp_hit(id)) e = id; else e = lowest_free();
        issue(4, id);
        chk($sformatf("R9 submit %0d", id), rsp_id, (e < 0) ? 0 : e);
        if (e >= 0) mdl[e] = 1'b1;
    endtask

    task automatic t_inval(int id);
        issue(3, id);
        chk("R8 wr_valid", wr_valid, 1);
        chk("R8 wr_slot", wr_slot, id);
        chk("R8 wr_key zero", (wr_key == '0), 1);
        chk("R8 ready low", req_ready, 0);
        chk("R8 no early rsp", rsp_valid, 0);
        repeat (3) @(negedge clk);
        chk("R8 wr held", wr_valid, 1);
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
        chk("R8 wr dropped", wr_valid, 0);
        chk("R8 rsp", rsp_valid, 1);
        chk("R8 rsp id", rsp_id, id);
        if (id != 14 && id != 15) mdl[id] = 1'b0;
        t_query(id);
    endtask

    task automatic t_inval_zero();
        issue(3, 0);
        chk("R7 no write", wr_valid, 0);
        chk("R7 rsp", rsp_valid, 1);
        chk("R7 fail", rsp_fail, 0);
        chk("R7 ready", req_ready, 1);
    endtask

    task automatic t_bad();
        issue(6, 3);
        chk("R6 bad op fail", rsp_fail, 1);
        chk("R6 bad op err", err_pulse, 1);
        issue(3, 20);
        chk("R6 inval oob err", err_pulse, 1);
        chk("R6 inval oob no write", wr_valid, 0);
    endtask

    task automatic t_back_to_back();
        int e;
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_id = 5'd4;
        @(negedge clk);
        mdl[4] = 1'b0;
        chk("R10 b2b free rsp", rsp_id, 4);
        req_op = 3'd2; req_id = 5'd4;
        @(negedge clk);
        chk("R10 b2b query after free", rsp_hit, 0);
        e = lowest_free();
        req_op = 3'd0; req_id = 5'd0;
        @(negedge clk);
        chk("R10 b2b alloc", rsp_id, e);
        mdl[e] = 1'b1;
        req_op = 3'd2; req_id = e[4:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 b2b query after alloc", rsp_hit, 1);
    endtask

    task automatic t_done_with_pending(int id);
        issue(3, id);
        chk("R8 pend wr_valid", wr_valid, 1);
        req_valid = 1'b1; req_op = 3'd2; req_id = id[4:0];
        @(negedge clk);
        chk("R8 pend not taken", req_ready, 0);
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
        mdl[id] = 1'b0;
        chk("R8 pend inval rsp", rsp_valid, 1);
        chk("R8 pend inval rsp_id", rsp_id, id);
        chk("R8 pend hit low", rsp_hit, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 pend query rsp", rsp_valid, 1);
        chk("R4 pend query freed", rsp_hit, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alloc("R1 first alloc");
        t_alloc("R2 alloc");
        t_alloc("R2 alloc");
        t_query(2); t_query(0); t_query(14); t_query(20); t_query(9);
        t_free(2);
        t_query(2);
        t_alloc("R5 realloc");
        t_free(0); t_free(15); t_free(17);
        t_alloc("R6 unchanged");
        t_submit(3); t_submit(9); t_submit(14);
        for (int k = 0; k < 14; k++) t_alloc("R2 fill");
        t_alloc("R3 full");
        t_inval_zero();
        t_alloc("R7 still full");
        t_bad();
        t_inval(5);
        t_alloc("R8 reuse");
        t_inval(14);
        t_query(14);
        t_back_to_back();
        t_done_with_pending(7);
        t_free(7);
        t_free(0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule